// File: doc/BRIEF.md
# Interrupt Controller Register Port

This block is the software-facing register port of an eight-line priority interrupt controller. A byte-wide data bus and a single address bit let a processor program the controller and read its state. The priority core, which holds the request and in-service registers and picks the winning line, sits beside this block. This block owns every programmable setting. It turns each write into either a configuration change or a one-cycle command strobe for the core.

Programming starts with a start word on address 0. That word resets every setting and opens a short sequence of follow-up words on address 1: the vector base, then a cascade word, then an optional extra word that selects nested and automatic end-of-interrupt behaviour. Once the sequence is done, address-1 writes load the interrupt mask. Address-0 writes carry either a read/poll/mask control word or a command word. The command words cover the end-of-interrupt variants, priority setting and rotation control.

Reads return the request, in-service or mask register. In poll mode, a read returns the core's best pending line and tells the core to retire it.

Top module: `irqc_regport`

## Requirements
- R1: After reset, all of the following are zero: every configuration output, `seq_phase`, `rdata` and all strobes.
- R2: An address-0 write with bit 4 set is a start word. It clears the mask, vector base, nested, auto-EOI, rotate, special-mask, read-select and poll settings. It sets `seq_phase` to 1, pulses `init_pulse`, and remembers bit 0 as "extra word wanted". This holds in any phase.
- R3: In phase 1, an address-1 write sets `vec_base` to the data with bits 2:0 forced to zero, moves to phase 2, and leaves `imr` untouched.
- R4: In phase 2, an address-1 write moves to phase 3 if the extra word was wanted, and to phase 0 otherwise. In phase 3, an address-1 write copies bit 4 to `nested_mode` and bit 1 to `auto_eoi`, then returns to phase 0.
- R5: In phase 0, an address-1 write loads `imr`. A read at address 1 outside poll mode returns `imr`.
- R6: An address-0 write with bit 4 clear and bit 3 set is a control word. Bit 2 set arms poll mode. Bit 1 set copies bit 0 to `read_isr`. Bit 6 set copies bit 5 to `spec_mask`. When bit 1 is clear, `read_isr` is unchanged. When bit 6 is clear, `spec_mask` is unchanged.
- R7: An address-0 write with bits 4 and 3 clear is a command word with opcode bits 7:5. Opcodes 0 and 4 copy bit 7 to `rot_aeoi` without a strobe. Opcode 2 has no effect. Opcodes 1, 3, 5, 6 and 7 pulse `cmd_stb`, with `cmd_op` set to the opcode and `cmd_line` set to bits 2:0.
- R8: A read at address 0 outside poll mode returns `core_isr` when `read_isr` is 1 and `core_irr` otherwise. `rdata` changes in the cycle after `rd_en` and holds between reads.
- R9: A read with poll armed returns `best_line` zero-extended and pulses `poll_clr_stb` with `poll_clr_line` equal to `best_line`, when `best_vld` is 1. When `best_vld` is 0 it returns 7 and gives no pulse. In both cases poll is disarmed afterwards.
- R10: `init_pulse`, `cmd_stb` and `poll_clr_stb` rise in the cycle after the access that causes them and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, data valid in the same cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| core_irr | input | 8 | Request register from the priority core |
| core_isr | input | 8 | In-service register from the priority core |
| best_vld | input | 1 | Core has a winning pending line |
| best_line | input | 3 | Winning pending line |
| rdata | output | 8 | Registered read data |
| imr | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| seq_phase | output | 2 | Programming sequence phase (0 = run) |
| nested_mode | output | 1 | Special nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| spec_mask | output | 1 | Special mask mode |
| read_isr | output | 1 | Address-0 read selects in-service register |
| poll_armed | output | 1 | Next read is a poll read |
| init_pulse | output | 1 | Start word seen: core clears state and drops its request |
| cmd_stb | output | 1 | Command strobe to the core |
| cmd_op | output | 3 | Command opcode |
| cmd_line | output | 3 | Line field of the command |
| poll_clr_stb | output | 1 | Poll read retired a line |
| poll_clr_line | output | 3 | Line to clear in request and in-service |

## Verification
The assertions take for granted that a read and a write never share a cycle. They also assume that the core's best-line inputs are settled in the read cycle, so every strobe can be traced to exactly one access. The stimulus drives all inputs on the falling clock edge and issues one access per transaction, with an idle cycle after each. It sweeps every write data value through each phase and word kind.

// File: rtl/irqc_regport_pkg.sv
package irqc_regport_pkg;
   typedef enum logic [1:0] {
      PH_RUN   = 2'd0,
      PH_BASE  = 2'd1,
      PH_CASC  = 2'd2,
      PH_EXTRA = 2'd3
   } seq_phase_e;

   localparam int unsigned START_BIT   = 4;
   localparam int unsigned CTRL_BIT    = 3;
   localparam int unsigned POLL_BIT    = 2;
   localparam int unsigned SEL_EN_BIT  = 1;
   localparam int unsigned SMM_EN_BIT  = 6;
   localparam int unsigned SMM_VAL_BIT = 5;
   localparam int unsigned NEST_BIT    = 4;
   localparam int unsigned AEOI_BIT    = 1;

   localparam logic [2:0] OP_ROT_CLR = 3'd0;
   localparam logic [2:0] OP_NOP     = 3'd2;
   localparam logic [2:0] OP_ROT_SET = 3'd4;
endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
   import irqc_regport_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned LW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_hit,
   input  logic          wr1,
   input  logic [DW-1:0] wdata,
   output seq_phase_e    phase,
   output logic [DW-1:0] imr,
   output logic [DW-1:0] vec_base,
   output logic          nested_mode,
   output logic          auto_eoi,
   output logic          init_pulse
);
   localparam logic [DW-1:0] BASE_MASK = {DW{1'b1}} << LW;

   logic need_extra;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase       <= PH_RUN;
         need_extra  <= 1'b0;
         imr         <= '0;
         vec_base    <= '0;
         nested_mode <= 1'b0;
         auto_eoi    <= 1'b0;
         init_pulse  <= 1'b0;
      end else begin
         init_pulse <= init_hit;
         if (init_hit) begin
            phase       <= PH_BASE;
            need_extra  <= wdata[0];
            imr         <= '0;
            vec_base    <= '0;
            nested_mode <= 1'b0;
            auto_eoi    <= 1'b0;
         end else if (wr1) begin
            case (phase)
               PH_RUN:  imr <= wdata;
               PH_BASE: begin
                  vec_base <= wdata & BASE_MASK;
                  phase    <= PH_CASC;
               end
               PH_CASC: phase <= need_extra ? PH_EXTRA : PH_RUN;
               default: begin
                  nested_mode <= wdata[NEST_BIT];
                  auto_eoi    <= wdata[AEOI_BIT];
                  phase       <= PH_RUN;
               end
            endcase
         end
      end
   end

   assert_base_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && !init_hit && phase == PH_BASE) |=> (phase == PH_CASC && vec_base[LW-1:0] == '0));
   assert_extra_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && !init_hit && phase == PH_EXTRA) |=> (phase == PH_RUN));
   assert_imr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_hit && !(wr1 && phase == PH_RUN)) |=> $stable(imr));
   assert_pulse_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      init_pulse |-> $past(init_hit));
endmodule

// File: rtl/irqc_cmd_dec.sv
module irqc_cmd_dec
   import irqc_regport_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned LW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_hit,
   input  logic          wr0,
   input  logic          rd_en,
   input  logic [DW-1:0] wdata,
   output logic          poll_armed,
   output logic          read_isr,
   output logic          spec_mask,
   output logic          rot_aeoi,
   output logic          cmd_stb,
   output logic [2:0]    cmd_op,
   output logic [LW-1:0] cmd_line
);
   logic [2:0] op;
   assign op = wdata[DW-1 -: 3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         poll_armed <= 1'b0;
         read_isr   <= 1'b0;
         spec_mask  <= 1'b0;
         rot_aeoi   <= 1'b0;
         cmd_stb    <= 1'b0;
         cmd_op     <= '0;
         cmd_line   <= '0;
      end else begin
         cmd_stb <= 1'b0;
         if (rd_en) poll_armed <= 1'b0;
         if (init_hit) begin
            poll_armed <= 1'b0;
            read_isr   <= 1'b0;
            spec_mask  <= 1'b0;
            rot_aeoi   <= 1'b0;
         end else if (wr0) begin
            if (wdata[CTRL_BIT]) begin
               if (wdata[POLL_BIT])   poll_armed <= 1'b1;
               if (wdata[SEL_EN_BIT]) read_isr   <= wdata[0];
               if (wdata[SMM_EN_BIT]) spec_mask  <= wdata[SMM_VAL_BIT];
            end else begin
               case (op)
                  OP_ROT_CLR, OP_ROT_SET: rot_aeoi <= wdata[DW-1];
                  OP_NOP: ;
                  default: begin
                     cmd_stb  <= 1'b1;
                     cmd_op   <= op;
                     cmd_line <= wdata[LW-1:0];
                  end
               endcase
            end
         end
      end
   end

   assert_stb_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> $past(wr0));
   assert_poll_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr0 && !init_hit) |=> !poll_armed);
endmodule

// File: rtl/irqc_rd_mux.sv
module irqc_rd_mux #(
   parameter int unsigned DW         = 8,
   parameter int unsigned LW         = 3,
   parameter bit          RDATA_HOLD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          addr,
   input  logic          poll_armed,
   input  logic          read_isr,
   input  logic [DW-1:0] core_irr,
   input  logic [DW-1:0] core_isr,
   input  logic [DW-1:0] imr,
   input  logic          best_vld,
   input  logic [LW-1:0] best_line,
   output logic [DW-1:0] rdata,
   output logic          poll_clr_stb,
   output logic [LW-1:0] poll_clr_line
);
   localparam logic [DW-1:0] IDLE_CODE = DW'((1 << LW) - 1);

   logic [DW-1:0] nxt;

   always_comb begin
      if (poll_armed)    nxt = best_vld ? DW'(best_line) : IDLE_CODE;
      else if (addr)     nxt = imr;
      else if (read_isr) nxt = core_isr;
      else               nxt = core_irr;
   end

   generate
      if (RDATA_HOLD) begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)     rdata <= '0;
            else if (rd_en) rdata <= nxt;
         end
         assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> $stable(rdata));
      end else begin : g_zero
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_en ? nxt : '0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         poll_clr_stb  <= 1'b0;
         poll_clr_line <= '0;
      end else begin
         poll_clr_stb  <= rd_en && poll_armed && best_vld;
         poll_clr_line <= best_line;
      end
   end

   assert_clr_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      poll_clr_stb |-> $past(rd_en && poll_armed && best_vld));
endmodule

// File: rtl/irqc_regport.sv
module irqc_regport
   import irqc_regport_pkg::*;
#(
   parameter int unsigned DW         = 8,
   parameter int unsigned N_LINES    = 8,
   parameter bit          RDATA_HOLD = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       rd_en,
   input  logic                       addr,
   input  logic [DW-1:0]              wdata,
   input  logic [DW-1:0]              core_irr,
   input  logic [DW-1:0]              core_isr,
   input  logic                       best_vld,
   input  logic [$clog2(N_LINES)-1:0] best_line,
   output logic [DW-1:0]              rdata,
   output logic [DW-1:0]              imr,
   output logic [DW-1:0]              vec_base,
   output logic [1:0]                 seq_phase,
   output logic                       nested_mode,
   output logic                       auto_eoi,
   output logic                       rot_aeoi,
   output logic                       spec_mask,
   output logic                       read_isr,
   output logic                       poll_armed,
   output logic                       init_pulse,
   output logic                       cmd_stb,
   output logic [2:0]                 cmd_op,
   output logic [$clog2(N_LINES)-1:0] cmd_line,
   output logic                       poll_clr_stb,
   output logic [$clog2(N_LINES)-1:0] poll_clr_line
);
   localparam int unsigned LW = $clog2(N_LINES);

   initial begin
      assert (DW == 8) else $error("irqc_regport: DW must be 8");
      assert (N_LINES == 8) else $error("irqc_regport: N_LINES must be 8");
   end

   logic       init_hit, wr0, wr1;
   seq_phase_e phase;

   assign init_hit  = wr_en && !addr && wdata[START_BIT];
   assign wr0       = wr_en && !addr && !wdata[START_BIT];
   assign wr1       = wr_en && addr;
   assign seq_phase = phase;

   irqc_init_seq #(.DW(DW), .LW(LW)) u_seq (
      .clk(clk), .rst_n(rst_n), .init_hit(init_hit), .wr1(wr1), .wdata(wdata),
      .phase(phase), .imr(imr), .vec_base(vec_base), .nested_mode(nested_mode),
      .auto_eoi(auto_eoi), .init_pulse(init_pulse)
   );

   irqc_cmd_dec #(.DW(DW), .LW(LW)) u_cmd (
      .clk(clk), .rst_n(rst_n), .init_hit(init_hit), .wr0(wr0), .rd_en(rd_en),
      .wdata(wdata), .poll_armed(poll_armed), .read_isr(read_isr),
      .spec_mask(spec_mask), .rot_aeoi(rot_aeoi), .cmd_stb(cmd_stb),
      .cmd_op(cmd_op), .cmd_line(cmd_line)
   );

   irqc_rd_mux #(.DW(DW), .LW(LW), .RDATA_HOLD(RDATA_HOLD)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
      .poll_armed(poll_armed), .read_isr(read_isr), .core_irr(core_irr),
      .core_isr(core_isr), .imr(imr), .best_vld(best_vld), .best_line(best_line),
      .rdata(rdata), .poll_clr_stb(poll_clr_stb), .poll_clr_line(poll_clr_line)
   );

   assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));
   assert_start_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      init_hit |=> (seq_phase == 2'd1 && init_pulse && imr == '0 && !poll_armed));
endmodule

// File: tb/sim_irqc_regport.sv
module sim_irqc_regport;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0, core_irr = '0, core_isr = '0;
   logic       best_vld = 1'b0;
   logic [2:0] best_line = '0;
   logic [7:0] rdata, imr, vec_base;
   logic [1:0] seq_phase;
   logic       nested_mode, auto_eoi, rot_aeoi, spec_mask, read_isr, poll_armed;
   logic       init_pulse, cmd_stb, poll_clr_stb;
   logic [2:0] cmd_op, cmd_line, poll_clr_line;

   always #10 clk = ~clk;

   irqc_regport u0 (.*);

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   logic [7:0] e_imr, e_vec;
   logic [1:0] e_phase;
   logic e_need, e_nest, e_aeoi, e_rot, e_smm, e_sel, e_poll, e_istb, e_cstb;
   logic [2:0] e_op, e_line;

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic mdl_clear();
      e_imr = 0; e_vec = 0; e_phase = 0; e_need = 0; e_nest = 0; e_aeoi = 0;
      e_rot = 0; e_smm = 0; e_sel = 0; e_poll = 0; e_istb = 0; e_cstb = 0;
      e_op = 0; e_line = 0;
   endtask

   task automatic mdl_wr(input logic a, input logic [7:0] d);
      e_istb = 0; e_cstb = 0;
      if (!a && d[4]) begin
         mdl_clear(); e_phase = 1; e_need = d[0]; e_istb = 1;
      end else if (a) begin
         case (e_phase)
            2'd0: e_imr = d;
            2'd1: begin e_vec = {d[7:3], 3'b000}; e_phase = 2; end
            2'd2: e_phase = e_need ? 2'd3 : 2'd0;
            default: begin e_nest = d[4]; e_aeoi = d[1]; e_phase = 0; end
         endcase
      end else if (d[3]) begin
         if (d[2]) e_poll = 1;
         if (d[1]) e_sel = d[0];
         if (d[6]) e_smm = d[5];
      end else begin
         case (d[7:5])
            3'd0, 3'd4: e_rot = d[7];
            3'd2: ;
            default: begin e_cstb = 1; e_op = d[7:5]; e_line = d[2:0]; end
         endcase
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " imr"}, imr, e_imr);
      chk({tag, " vec_base"}, vec_base, e_vec);
      chk({tag, " phase"}, seq_phase, e_phase);
      chk({tag, " nested"}, nested_mode, e_nest);
      chk({tag, " aeoi"}, auto_eoi, e_aeoi);
      chk({tag, " rot"}, rot_aeoi, e_rot);
      chk({tag, " smm"}, spec_mask, e_smm);
      chk({tag, " sel"}, read_isr, e_sel);
      chk({tag, " poll"}, poll_armed, e_poll);
      chk({tag, " init_pulse"}, init_pulse, e_istb);
      chk({tag, " cmd_stb"}, cmd_stb, e_cstb);
      if (e_cstb) begin
         chk({tag, " cmd_op"}, cmd_op, e_op);
         chk({tag, " cmd_line"}, cmd_line, e_line);
      end
   endtask

   // one write, then compare at the falling edge after the capturing edge
   task automatic wr(input logic a, input logic [7:0] d, input string tag);
      mdl_wr(a, d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check_all(tag);
      @(negedge clk);
      chk({tag, " strobe one cycle R10"}, {29'd0, init_pulse, cmd_stb, poll_clr_stb}, 0);
   endtask

   task automatic rd(input logic a);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      mdl_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_all("R1");
      chk("R1 rdata", rdata, 0);
      chk("R1 poll_clr_stb", poll_clr_stb, 0);

      // R2/R3/R4: full programming sweep over every data value
      for (int v = 0; v < 256; v++) begin
         wr(1'b0, 8'h0C, "R6 arm");
         wr(1'b1, 8'(v ^ 8'h5A), "R5 pre");
         wr(1'b0, 8'h10 | 8'(v & 1), "R2");
         wr(1'b1, 8'(v), "R3");
         wr(1'b1, 8'(~v), "R4 casc");
         if (v[0]) wr(1'b1, 8'(v), "R4 extra");
      end

      // R2: start word mid-sequence restarts it
      wr(1'b0, 8'h11, "R2 start");
      wr(1'b1, 8'h48, "R3 base");
      wr(1'b0, 8'h10, "R2 restart");
      wr(1'b1, 8'h00, "R3 base2");
      wr(1'b1, 8'h00, "R4 casc2");

      // R5: mask write and readback sweep
      for (int v = 0; v < 256; v++) begin
         wr(1'b1, 8'(v), "R5");
         rd(1'b1);
         chk("R5 read imr", rdata, v);
      end

      // R6/R7: every address-0 value without the start bit
      for (int v = 0; v < 256; v++) begin
         if (v[4]) continue;
         wr(1'b0, 8'(v), v[3] ? "R6" : "R7");
         if (e_poll) begin
            best_vld = 1'b0;
            rd(1'b0);
            e_poll = 0;
            chk("R9 empty poll code", rdata, 7);
            chk("R9 no clear strobe", poll_clr_stb, 0);
            chk("R9 poll disarmed", poll_armed, 0);
         end
      end

      // R8: register reads under both selections, and hold between reads
      for (int v = 0; v < 32; v++) begin
         logic [7:0] irrp, isrp;
         irrp = 8'((v * 37 + 5) & 255);
         isrp = 8'((v * 91 + 200) & 255);
         core_irr = irrp; core_isr = isrp;
         wr(1'b0, {6'b000010, 1'b1, v[0]}, "R6 sel");
         rd(1'b0);
         chk("R8 read", rdata, v[0] ? isrp : irrp);
         core_irr = ~irrp; core_isr = ~isrp;
         @(negedge clk);
         chk("R8 hold", rdata, v[0] ? isrp : irrp);
      end

      // R9/R10: poll reads for every line and the empty case
      for (int v = 0; v < 16; v++) begin
         wr(1'b0, 8'h0C, "R6 poll arm");
         best_vld = v[3];
         best_line = 3'(v);
         rd(1'b0);
         e_poll = 0;
         chk("R9 poll data", rdata, v[3] ? (v & 7) : 7);
         chk("R9 clear strobe", poll_clr_stb, v[3]);
         if (v[3]) chk("R9 clear line", poll_clr_line, v & 7);
         chk("R9 disarmed", poll_armed, 0);
         @(negedge clk);
         chk("R10 clear strobe one cycle", poll_clr_stb, 0);
         best_vld = 1'b0;
         rd(1'b1);
         chk("R5 read after poll", rdata, e_imr);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule